// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns an operand addressing request into a real-mode physical memory address. A request carries an addressing mode, the current contents of the pointer registers (two base registers and two index registers), the four segment registers, a displacement, an index scale code and an optional segment-override request. The unit adds the terms the mode selects into a 16-bit offset, picks the segment, and forms the 20-bit physical address as the segment times sixteen plus the offset.

The default segment follows the registers taking part: when the stack-frame base register is one of the terms, the stack segment is used, and otherwise the data segment. An override request replaces that choice with any of the four segments. The index term can be multiplied by 1, 2, 4 or 8 in the scaled mode. The offset, the chosen segment and the physical address are registered together with a valid flag, one clock after the request is accepted, and they hold their values until the next request.

Top module: `seg_addr_gen`

## Requirements
- R1: When `out_vld` is 1, `out_phys` equals (`out_segment` << 4) + `out_offset`, truncated to 20 bits (the physical sum wraps modulo 2^20).
- R2: Mode codes on `mode`: 0 = displacement only; 2 = base + index; 4 = base + index + displacement; 5 = base + scaled index + displacement; 6 and 7 behave as code 0. The base term is the base-frame register when `base_sel` = 1 and the general base register when 0; the index term is the second index register when `idx_sel` = 1 and the first when 0.
- R3: Mode 1 uses a single pointer register alone and mode 3 uses that register plus the displacement; `ptr_sel` picks it: 0 = `reg_bx`, 1 = `reg_bp`, 2 = `reg_si`, 3 = `reg_di`. The displacement is ignored in mode 1.
- R4: Without an override, the segment is `seg_ss` when `reg_bp` takes part in the offset (base term with `base_sel` = 1 in modes 2, 4, 5, or `ptr_sel` = 1 in modes 1, 3), and `seg_ds` in every other case.
- R5: When `ovr_en` = 1, the segment is chosen by `ovr_sel`: 0 = `seg_ds`, 1 = `seg_ss`, 2 = `seg_es`, 3 = `seg_cs`, whatever registers take part.
- R6: In mode 5 the index term is shifted left by `scale` (0 = x1, 1 = x2, 2 = x4, 3 = x8) before the addition; in every other mode `scale` has no effect.
- R7: The offset is the sum of its terms modulo 2^16.
- R8: When `disp_short` = 1, the displacement term is bits 7:0 of `disp` sign-extended to 16 bits and bits 15:8 are ignored; when 0, all 16 bits are used unchanged.
- R9: A request with `req_vld` = 1 at a rising edge appears on the outputs after that edge with `out_vld` = 1; with `req_vld` = 0, `out_vld` is 0 after the edge and the offset, segment and physical outputs keep their values.
- R10: A synchronous active-high `rst` clears `out_vld`, `out_offset`, `out_segment` and `out_phys` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request accepted at this edge |
| mode | input | 3 | Addressing mode code |
| base_sel | input | 1 | Base term select: 0 general base, 1 frame base |
| idx_sel | input | 1 | Index term select: 0 first index, 1 second index |
| ptr_sel | input | 2 | Single pointer select for modes 1 and 3 |
| scale | input | 2 | Index scale code, mode 5 only |
| disp | input | 16 | Displacement |
| disp_short | input | 1 | Sign-extend displacement from 8 bits |
| ovr_en | input | 1 | Segment override request |
| ovr_sel | input | 2 | Override segment choice |
| reg_bx | input | 16 | General base register value |
| reg_bp | input | 16 | Frame base register value |
| reg_si | input | 16 | First index register value |
| reg_di | input | 16 | Second index register value |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| out_vld | output | 1 | Outputs carry a new result |
| out_offset | output | 16 | Effective offset |
| out_segment | output | 16 | Selected segment value |
| out_phys | output | 20 | Physical address |

## Verification
Every result of this block (offset, segment, physical address and valid flag) is due exactly one rising edge after the edge that samples `req_vld` = 1; nothing is spread over further cycles. The bench drives a request on a falling edge, lets one rising edge capture it, and reads all four outputs on the next falling edge, half a period away from any capture. The hold behaviour is checked one falling edge after an idle edge at which every register input was changed, so a leak of new operands into the held outputs would show at once.

// File: rtl/sag_pkg.sv
package sag_pkg;

    localparam int OFS_W  = 16;
    localparam int SEG_SH = 4;
    localparam int PHYS_W = OFS_W + SEG_SH;
    localparam int SHORT_W = 8;

    typedef enum logic [2:0] {
        AM_DIRECT = 3'd0,
        AM_RIND   = 3'd1,
        AM_BIDX   = 3'd2,
        AM_RREL   = 3'd3,
        AM_BIDX_D = 3'd4,
        AM_SCALED = 3'd5
    } amode_e;

    typedef enum logic [1:0] {
        SG_DS = 2'd0,
        SG_SS = 2'd1,
        SG_ES = 2'd2,
        SG_CS = 2'd3
    } segsel_e;

    typedef enum logic [1:0] {
        PT_BX = 2'd0,
        PT_BP = 2'd1,
        PT_SI = 2'd2,
        PT_DI = 2'd3
    } ptr_e;

    typedef struct packed {
        logic use_base;
        logic use_idx;
        logic use_ptr;
        logic use_disp;
        logic scaled;
    } terms_t;

    function automatic terms_t decode_mode(input logic [2:0] m);
        terms_t t;
        t = '0;
        case (m)
            AM_RIND:   begin t.use_ptr = 1'b1; end
            AM_BIDX:   begin t.use_base = 1'b1; t.use_idx = 1'b1; end
            AM_RREL:   begin t.use_ptr = 1'b1; t.use_disp = 1'b1; end
            AM_BIDX_D: begin t.use_base = 1'b1; t.use_idx = 1'b1; t.use_disp = 1'b1; end
            AM_SCALED: begin t.use_base = 1'b1; t.use_idx = 1'b1; t.use_disp = 1'b1;
                             t.scaled = 1'b1; end
            default:   begin t.use_disp = 1'b1; end
        endcase
        return t;
    endfunction

    function automatic logic [OFS_W-1:0] disp_extend(input logic [OFS_W-1:0] d,
                                                     input logic short8);
        return short8 ? {{(OFS_W-SHORT_W){d[SHORT_W-1]}}, d[SHORT_W-1:0]} : d;
    endfunction

    function automatic logic [OFS_W-1:0] apply_scale(input logic [OFS_W-1:0] v,
                                                     input logic [1:0] sc);
        return v << sc;
    endfunction

endpackage

// File: rtl/sag_offset_calc.sv
module sag_offset_calc
    import sag_pkg::*;
#(
    parameter int W = OFS_W,
    parameter bit HAS_SCALE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   mode,
    input  logic         base_sel,
    input  logic         idx_sel,
    input  logic [1:0]   ptr_sel,
    input  logic [1:0]   scale,
    input  logic [W-1:0] disp,
    input  logic         disp_short,
    input  logic [W-1:0] bx,
    input  logic [W-1:0] bp,
    input  logic [W-1:0] si,
    input  logic [W-1:0] di,
    output logic [W-1:0] offset,
    output logic         bp_used
);

    terms_t       terms;
    logic [W-1:0] base_v;
    logic [W-1:0] idx_v;
    logic [W-1:0] idx_s;
    logic [W-1:0] ptr_v;
    logic [W-1:0] disp_v;

    assign terms  = decode_mode(mode);
    assign base_v = base_sel ? bp : bx;
    assign idx_v  = idx_sel  ? di : si;
    assign disp_v = disp_extend(disp, disp_short);

    always_comb begin
        case (ptr_sel)
            PT_BX:   ptr_v = bx;
            PT_BP:   ptr_v = bp;
            PT_SI:   ptr_v = si;
            default: ptr_v = di;
        endcase
    end

    generate
        if (HAS_SCALE) begin : g_scale
            assign idx_s = terms.scaled ? apply_scale(idx_v, scale) : idx_v;
        end else begin : g_noscale
            assign idx_s = idx_v;
        end
    endgenerate

    // Offset sum: every term is W bits so the addition wraps modulo 2^W.
    assign offset = (terms.use_base ? base_v : '0)
                  + (terms.use_idx  ? idx_s  : '0)
                  + (terms.use_ptr  ? ptr_v  : '0)
                  + (terms.use_disp ? disp_v : '0);

    assign bp_used = (terms.use_base && base_sel) ||
                     (terms.use_ptr  && (ptr_sel == PT_BP));

    // R2: displacement-only modes give the extended displacement
    p_direct_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == AM_DIRECT) |-> (offset == disp_extend(disp, disp_short)))
        else $error("p_direct_r2");

    // R3: single-register indirect through the first index register
    p_ptr_only_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == AM_RIND && ptr_sel == PT_SI) |-> (offset == si))
        else $error("p_ptr_only_r3");

    // R6: scale code ignored outside the scaled mode
    p_noscale_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == AM_BIDX) |-> (offset == W'(base_v + idx_v)))
        else $error("p_noscale_r6");

endmodule

// File: rtl/sag_seg_pick.sv
module sag_seg_pick
    import sag_pkg::*;
#(
    parameter int W = OFS_W,
    parameter int NSEG = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ds,
    input  logic [W-1:0] ss,
    input  logic [W-1:0] es,
    input  logic [W-1:0] cs,
    input  logic         bp_used,
    input  logic         ovr_en,
    input  logic [1:0]   ovr_sel,
    output logic [W-1:0] seg
);

    logic [W-1:0] seg_tbl [NSEG];
    logic [1:0]   pick;

    assign seg_tbl[SG_DS] = ds;
    assign seg_tbl[SG_SS] = ss;
    assign seg_tbl[SG_ES] = es;
    assign seg_tbl[SG_CS] = cs;

    always_comb begin
        if (ovr_en)       pick = ovr_sel;
        else if (bp_used) pick = SG_SS;
        else              pick = SG_DS;
    end

    assign seg = seg_tbl[pick];

    // R5: override to the code segment wins over any default
    p_override_r5: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && ovr_sel == SG_CS) |-> (seg == cs))
        else $error("p_override_r5");

    // R4: no override and no frame base gives the data segment
    p_default_ds_r4: assert property (@(posedge clk) disable iff (rst)
        (!ovr_en && !bp_used) |-> (seg == ds))
        else $error("p_default_ds_r4");

endmodule

// File: rtl/sag_out_stage.sv
module sag_out_stage
    import sag_pkg::*;
#(
    parameter int W  = OFS_W,
    parameter int SH = SEG_SH,
    localparam int PW = W + SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [W-1:0]  in_offset,
    input  logic [W-1:0]  in_seg,
    output logic          q_vld,
    output logic [W-1:0]  q_offset,
    output logic [W-1:0]  q_seg,
    output logic [PW-1:0] q_phys
);

    logic [PW-1:0] phys_d;

    // Segment shifted by SH plus zero-extended offset, wrapping modulo 2^PW.
    assign phys_d = {in_seg, {SH{1'b0}}} + {{SH{1'b0}}, in_offset};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld    <= 1'b0;
            q_offset <= '0;
            q_seg    <= '0;
            q_phys   <= '0;
        end else begin
            q_vld <= in_vld;
            if (in_vld) begin
                q_offset <= in_offset;
                q_seg    <= in_seg;
                q_phys   <= phys_d;
            end
        end
    end

    // R1: registered physical address agrees with registered segment and offset
    p_phys_sum_r1: assert property (@(posedge clk) disable iff (rst)
        q_vld |-> (q_phys == PW'({q_seg, {SH{1'b0}}} + {{SH{1'b0}}, q_offset})))
        else $error("p_phys_sum_r1");

    // R9: accepted request yields valid after one edge
    p_vld_rise_r9: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> q_vld)
        else $error("p_vld_rise_r9");

    // R9: idle edge drops valid and holds the address
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!q_vld && $stable(q_phys) && $stable(q_offset) && $stable(q_seg)))
        else $error("p_hold_r9");

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import sag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [2:0]        mode,
    input  logic              base_sel,
    input  logic              idx_sel,
    input  logic [1:0]        ptr_sel,
    input  logic [1:0]        scale,
    input  logic [OFS_W-1:0]  disp,
    input  logic              disp_short,
    input  logic              ovr_en,
    input  logic [1:0]        ovr_sel,
    input  logic [OFS_W-1:0]  reg_bx,
    input  logic [OFS_W-1:0]  reg_bp,
    input  logic [OFS_W-1:0]  reg_si,
    input  logic [OFS_W-1:0]  reg_di,
    input  logic [OFS_W-1:0]  seg_ds,
    input  logic [OFS_W-1:0]  seg_ss,
    input  logic [OFS_W-1:0]  seg_es,
    input  logic [OFS_W-1:0]  seg_cs,
    output logic              out_vld,
    output logic [OFS_W-1:0]  out_offset,
    output logic [OFS_W-1:0]  out_segment,
    output logic [PHYS_W-1:0] out_phys
);

    logic [OFS_W-1:0] ofs_c;
    logic [OFS_W-1:0] seg_c;
    logic             bp_in_use;

    sag_offset_calc #(.W(OFS_W), .HAS_SCALE(1'b1)) u_ofs (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .base_sel   (base_sel),
        .idx_sel    (idx_sel),
        .ptr_sel    (ptr_sel),
        .scale      (scale),
        .disp       (disp),
        .disp_short (disp_short),
        .bx         (reg_bx),
        .bp         (reg_bp),
        .si         (reg_si),
        .di         (reg_di),
        .offset     (ofs_c),
        .bp_used    (bp_in_use)
    );

    sag_seg_pick #(.W(OFS_W), .NSEG(4)) u_seg (
        .clk     (clk),
        .rst     (rst),
        .ds      (seg_ds),
        .ss      (seg_ss),
        .es      (seg_es),
        .cs      (seg_cs),
        .bp_used (bp_in_use),
        .ovr_en  (ovr_en),
        .ovr_sel (ovr_sel),
        .seg     (seg_c)
    );

    sag_out_stage #(.W(OFS_W), .SH(SEG_SH)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (req_vld),
        .in_offset (ofs_c),
        .in_seg    (seg_c),
        .q_vld     (out_vld),
        .q_offset  (out_offset),
        .q_seg     (out_segment),
        .q_phys    (out_phys)
    );

    // R4: frame base in a base+index request selects the stack segment
    p_bp_stack_r4: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !ovr_en && mode == AM_BIDX && base_sel) |=> (out_segment == $past(seg_ss)))
        else $error("p_bp_stack_r4");

endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [2:0]  mode = '0;
    logic        base_sel = 1'b0;
    logic        idx_sel = 1'b0;
    logic [1:0]  ptr_sel = '0;
    logic [1:0]  scale = '0;
    logic [15:0] disp = '0;
    logic        disp_short = 1'b0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [15:0] seg_ds = '0, seg_ss = '0, seg_es = '0, seg_cs = '0;
    logic        out_vld;
    logic [15:0] out_offset;
    logic [15:0] out_segment;
    logic [19:0] out_phys;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst(rst), .req_vld(req_vld), .mode(mode),
        .base_sel(base_sel), .idx_sel(idx_sel), .ptr_sel(ptr_sel),
        .scale(scale), .disp(disp), .disp_short(disp_short),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_es(seg_es), .seg_cs(seg_cs),
        .out_vld(out_vld), .out_offset(out_offset),
        .out_segment(out_segment), .out_phys(out_phys)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        mode = '0; base_sel = 0; idx_sel = 0; ptr_sel = '0; scale = '0;
        disp = '0; disp_short = 0; ovr_en = 0; ovr_sel = '0;
        reg_bx = '0; reg_bp = '0; reg_si = '0; reg_di = '0;
        seg_ds = '0; seg_ss = '0; seg_es = '0; seg_cs = '0;
    endtask

    // Inputs already set; present request on a falling edge, one rising
    // edge captures it, results read on the following falling edge.
    task automatic fire(input string req, input logic [15:0] eo,
                        input logic [15:0] es, input logic [19:0] ep);
        req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
        chk({req, " R9 vld"}, 32'(out_vld), 32'd1);
        chk({req, " offset"}, 32'(out_offset), 32'(eo));
        chk({req, " segment"}, 32'(out_segment), 32'(es));
        chk({req, " R1 phys"}, 32'(out_phys), 32'(ep));
    endtask

    task automatic t_reset();
        clear_inputs();
        seg_ds = 16'h1234; disp = 16'h0042; req_vld = 1'b1;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 vld", 32'(out_vld), 0);
        chk("R10 offset", 32'(out_offset), 0);
        chk("R10 segment", 32'(out_segment), 0);
        chk("R10 phys", 32'(out_phys), 0);
        req_vld = 1'b0; rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_base_index();
        clear_inputs();
        seg_ds = 16'h0100; reg_bx = 16'h1000; reg_di = 16'h0010;
        mode = 3'd2; base_sel = 0; idx_sel = 1;
        fire("R2 base+index ref", 16'h1010, 16'h0100, 20'h02010);
        clear_inputs();
        seg_ss = 16'h2000; seg_ds = 16'h0300; reg_bp = 16'h0010; reg_si = 16'h0004;
        mode = 3'd2; base_sel = 1; idx_sel = 0;
        fire("R4 frame base+index", 16'h0014, 16'h2000, 20'h20014);
    endtask

    task automatic t_frame_rel();
        clear_inputs();
        seg_ss = 16'h1400; seg_ds = 16'h0999; reg_bp = 16'h1500; disp = 16'h0200;
        mode = 3'd3; ptr_sel = 2'd1;
        fire("R3 R4 frame relative ref", 16'h1700, 16'h1400, 20'h15700);
    endtask

    task automatic t_direct();
        clear_inputs();
        seg_ds = 16'h1000; disp = 16'h1234; reg_bx = 16'h0F0F; reg_si = 16'h0101;
        mode = 3'd0;
        fire("R2 direct", 16'h1234, 16'h1000, 20'h11234);
        mode = 3'd7;
        fire("R2 reserved code as direct", 16'h1234, 16'h1000, 20'h11234);
        mode = 3'd4; base_sel = 0; idx_sel = 0;
        fire("R2 base+index+disp", 16'h2244, 16'h1000, 20'h12244);
    endtask

    task automatic t_indirect();
        clear_inputs();
        seg_ds = 16'h0000; seg_ss = 16'h0100;
        reg_bx = 16'h0011; reg_bp = 16'h0022; reg_si = 16'h0033; reg_di = 16'h0044;
        disp = 16'h5555; mode = 3'd1;
        ptr_sel = 2'd0; fire("R3 indirect bx", 16'h0011, 16'h0000, 20'h00011);
        ptr_sel = 2'd1; fire("R3 R4 indirect bp", 16'h0022, 16'h0100, 20'h01022);
        ptr_sel = 2'd2; fire("R3 indirect si", 16'h0033, 16'h0000, 20'h00033);
        ptr_sel = 2'd3; fire("R3 indirect di", 16'h0044, 16'h0000, 20'h00044);
    endtask

    task automatic t_scaled();
        clear_inputs();
        reg_bx = 16'h0100; reg_si = 16'h0003; disp = 16'h0010; mode = 3'd5;
        scale = 2'd0; fire("R6 scale x1", 16'h0113, 16'h0000, 20'h00113);
        scale = 2'd1; fire("R6 scale x2", 16'h0116, 16'h0000, 20'h00116);
        scale = 2'd2; fire("R6 scale x4", 16'h011C, 16'h0000, 20'h0011C);
        scale = 2'd3; fire("R6 scale x8", 16'h0128, 16'h0000, 20'h00128);
        mode = 3'd4;
        fire("R6 scale ignored mode4", 16'h0113, 16'h0000, 20'h00113);
        seg_ss = 16'h0500; reg_bp = 16'h0100; base_sel = 1; mode = 3'd5;
        fire("R4 R6 scaled frame base", 16'h0128, 16'h0500, 20'h05128);
    endtask

    task automatic t_override();
        clear_inputs();
        seg_ds = 16'h0500; seg_ss = 16'h0700; seg_es = 16'h3000; seg_cs = 16'hF000;
        reg_bp = 16'h0010; reg_bx = 16'h0020;
        mode = 3'd3; ptr_sel = 2'd1; ovr_en = 1;
        ovr_sel = 2'd2; fire("R5 override es", 16'h0010, 16'h3000, 20'h30010);
        ovr_sel = 2'd0; fire("R5 override ds over bp", 16'h0010, 16'h0500, 20'h05010);
        mode = 3'd1; ptr_sel = 2'd0; ovr_sel = 2'd1;
        fire("R5 override ss over bx", 16'h0020, 16'h0700, 20'h07020);
        mode = 3'd0; disp = 16'h0100; ovr_sel = 2'd3;
        fire("R5 override cs", 16'h0100, 16'hF000, 20'hF0100);
    endtask

    task automatic t_wrap();
        clear_inputs();
        seg_ds = 16'h0200; reg_bx = 16'hFFF0; reg_si = 16'h0030; disp = 16'h0010;
        mode = 3'd4;
        fire("R7 offset wrap", 16'h0030, 16'h0200, 20'h02030);
        clear_inputs();
        seg_cs = 16'hFFFF; ovr_en = 1; ovr_sel = 2'd3; disp = 16'h0020; mode = 3'd0;
        fire("R1 phys wrap", 16'h0020, 16'hFFFF, 20'h00010);
    endtask

    task automatic t_short_disp();
        clear_inputs();
        mode = 3'd0; disp = 16'h12F0; disp_short = 1;
        fire("R8 short negative", 16'hFFF0, 16'h0000, 20'h0FFF0);
        disp = 16'h3470;
        fire("R8 short positive upper ignored", 16'h0070, 16'h0000, 20'h00070);
        mode = 3'd3; ptr_sel = 2'd0; reg_bx = 16'h0100; disp = 16'h0080;
        fire("R8 short rel", 16'h0080, 16'h0000, 20'h00080);
        disp_short = 0;
        fire("R8 long rel", 16'h0180, 16'h0000, 20'h00180);
    endtask

    task automatic t_hold();
        clear_inputs();
        seg_ds = 16'h0400; reg_bx = 16'h0002; mode = 3'd1;
        fire("R9 hold setup", 16'h0002, 16'h0400, 20'h04002);
        reg_bx = 16'h7777; seg_ds = 16'h8888; seg_ss = 16'h9999; disp = 16'h1111; mode = 3'd4;
        @(negedge clk);
        chk("R9 idle vld low", 32'(out_vld), 0);
        chk("R9 hold offset", 32'(out_offset), 32'h0002);
        chk("R9 hold segment", 32'(out_segment), 32'h0400);
        chk("R9 hold phys", 32'(out_phys), 32'h04002);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_base_index();
        t_frame_rel();
        t_direct();
        t_indirect();
        t_scaled();
        t_override();
        t_wrap();
        t_short_disp();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule